// File: doc/BRIEF.md
# Slot-Mapped Programmable Interrupt Prioritizer

This block turns a wide set of pending peripheral interrupt requests into a single pending flag and one winning source code. Priority is not tied to the source number. Each source takes its rank from a position in a priority table. For two peripheral classes and one pin class, that position is reached indirectly, through a slot that software assigns at run time.

Four serial channels (IDs 1..4) are placed in the eight Y slots. Three fast channels and two multi-channel controllers (IDs 5..9) are placed in the eight X slots. Five general request pins, a periodic timer and a timer counter (IDs 10..16) are placed in the eight Z slots. A bus-error source (ID 0) always sits at the top of the table. Two fixed request pins (IDs 17, 18), two serial-management sources (IDs 19, 20) and two parallel-port sources (IDs 21, 22) occupy fixed places near the bottom.

A layout bit selects one of two table arrangements. In the grouped arrangement the Y slots lead the table. In the spread arrangement the X and Y slots are interleaved, and the last two Y slots sink among the fixed low sources. Software rotates priority by rewriting the slot maps. The layout bit may only be changed while the configuration input is held.

Top module: `slot_irq_prio`

## Requirements
- R1: After reset, irq_o is 0, vec_o is 31 (no source), cfg_err_o is 0, every enable is 0, the layout is grouped, and source k of each mapped class sits in slot k.
- R2: Register writes use these addresses. Address 0 holds the Y map: serial source k (ID 1+k) is in bits [3k+2:3k]. Address 1 holds the X map: source k (ID 5+k) is in bits [3k+2:3k]. Address 2 holds the Z map: source k (ID 10+k) is in bits [3k+2:3k]. Address 3 holds the enables: bit n enables source ID n. Address 4 holds the layout in bit 0 (0 grouped, 1 spread). A write takes effect at the clock edge that samples it, and writes to addresses 5..7 have no effect.
- R3: An enabled bus-error request (ID 0) always wins. The fixed sources keep the order 17, 18, 19, 20, 21, 22 in the grouped layout and sit below every X, Z and grouped Y slot.
- R4: Grouped table order, from highest to lowest: ID 0, Y1..Y8, X1..X8, Z1..Z8, IDs 17, 18, 19, 20, 21, 22.
- R5: Spread table order, from highest to lowest: ID 0, X1, Y1, X2, Y2 and so on up to X6, Y6, then X7, X8, Z1..Z8, IDs 17, 18, 19, Y7, IDs 20, 21, 22, Y8.
- R6: A rewritten slot map changes the arbitration result from the first edge after the write.
- R7: A layout write is applied only in a cycle where cfg_mode_i is high. Otherwise it is ignored.
- R8: If two sources of one class claim the same slot, the lower-numbered source keeps the slot and the other can never win. cfg_err_o is set one cycle after such a map appears and stays set until reset.
- R9: irq_o is registered each cycle as the OR of all requests that are enabled and not displaced from their slot.
- R10: At an edge where ack_i is high, vec_o loads the highest-priority eligible source, or 31 if there is none. Without ack_i, vec_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 23 | Request line per source ID |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| cfg_mode_i | input | 1 | Configuration state; unlocks layout writes |
| ack_i | input | 1 | Latch the current winner into vec_o |
| irq_o | output | 1 | Some eligible request is pending |
| vec_o | output | 5 | Latched winning source ID, 31 when none |
| cfg_err_o | output | 1 | Sticky slot-collision flag |

## Verification
irq_o and a vec_o loaded by ack_i are due one edge after the requests, enables and maps they depend on. A register write counts from the edge that samples it, so it first affects arbitration at the following edge. cfg_err_o follows a colliding map one edge after the map is stored. The bench drives each cycle's inputs after a falling edge. It computes the expected outputs for the next rising edge from its model state before applying that cycle's write to the model, and compares at the next falling edge. This keeps every check aligned with exactly one register stage.

// File: rtl/slot_irq_prio_pkg.sv
package slot_irq_prio_pkg;

   typedef enum logic [2:0] {
      REG_YMAP   = 3'd0,
      REG_XMAP   = 3'd1,
      REG_ZMAP   = 3'd2,
      REG_ENABLE = 3'd3,
      REG_LAYOUT = 3'd4
   } reg_addr_e;

   typedef enum logic {
      LAYOUT_GROUP  = 1'b0,
      LAYOUT_SPREAD = 1'b1
   } layout_e;

   // number of fixed low-priority sources after the Z slots
   localparam int FIXED_SRCS = 6;

   function automatic int y_pos(input int s, input int slots, input layout_e lay);
      if (lay == LAYOUT_GROUP) return 1 + s;
      if (s < slots - 2)       return 2 + 2 * s;
      if (s == slots - 2)      return 3 * slots + 2;
      return 3 * slots + 6;
   endfunction

   function automatic int x_pos(input int s, input int slots, input layout_e lay);
      if (lay == LAYOUT_GROUP) return 1 + slots + s;
      if (s < slots - 2)       return 1 + 2 * s;
      if (s == slots - 2)      return 2 * slots - 3;
      return 2 * slots - 2;
   endfunction

   function automatic int z_pos(input int s, input int slots, input layout_e lay);
      if (lay == LAYOUT_GROUP) return 1 + 2 * slots + s;
      return 2 * slots - 1 + s;
   endfunction

   function automatic int f_pos(input int f, input int slots, input layout_e lay);
      int base;
      if (lay == LAYOUT_GROUP) return 3 * slots + 1 + f;
      base = 3 * slots - 1;
      case (f)
         0:       return base;
         1:       return base + 1;
         2:       return base + 2;
         3:       return base + 4;
         4:       return base + 5;
         default: return base + 6;
      endcase
   endfunction

endpackage

// File: rtl/slot_irq_prio_regs.sv
module slot_irq_prio_regs
   import slot_irq_prio_pkg::*;
#(
   parameter int N_Y    = 4,
   parameter int N_X    = 5,
   parameter int N_Z    = 7,
   parameter int SLOT_W = 3,
   parameter int NSRC   = 23,
   parameter int DATA_W = 32
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    wr_en_i,
   input  logic [2:0]              wr_addr_i,
   input  logic [DATA_W-1:0]       wr_data_i,
   input  logic                    cfg_mode_i,
   output logic [N_Y-1:0][SLOT_W-1:0] y_map_o,
   output logic [N_X-1:0][SLOT_W-1:0] x_map_o,
   output logic [N_Z-1:0][SLOT_W-1:0] z_map_o,
   output logic [NSRC-1:0]         en_o,
   output layout_e                 layout_o
);

   logic [N_Y-1:0][SLOT_W-1:0] y_rst;
   logic [N_X-1:0][SLOT_W-1:0] x_rst;
   logic [N_Z-1:0][SLOT_W-1:0] z_rst;

   for (genvar k = 0; k < N_Y; k++) begin : g_yrst
      assign y_rst[k] = SLOT_W'(k);
   end
   for (genvar k = 0; k < N_X; k++) begin : g_xrst
      assign x_rst[k] = SLOT_W'(k);
   end
   for (genvar k = 0; k < N_Z; k++) begin : g_zrst
      assign z_rst[k] = SLOT_W'(k);
   end

   logic wr_y, wr_x, wr_z, wr_en_mask, wr_lay;
   always_comb begin
      wr_y       = wr_en_i && (wr_addr_i == REG_YMAP);
      wr_x       = wr_en_i && (wr_addr_i == REG_XMAP);
      wr_z       = wr_en_i && (wr_addr_i == REG_ZMAP);
      wr_en_mask = wr_en_i && (wr_addr_i == REG_ENABLE);
      wr_lay     = wr_en_i && (wr_addr_i == REG_LAYOUT) && cfg_mode_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         y_map_o  <= y_rst;
         x_map_o  <= x_rst;
         z_map_o  <= z_rst;
         en_o     <= '0;
         layout_o <= LAYOUT_GROUP;
      end else begin
         if (wr_y)       y_map_o  <= wr_data_i[N_Y*SLOT_W-1:0];
         if (wr_x)       x_map_o  <= wr_data_i[N_X*SLOT_W-1:0];
         if (wr_z)       z_map_o  <= wr_data_i[N_Z*SLOT_W-1:0];
         if (wr_en_mask) en_o     <= wr_data_i[NSRC-1:0];
         if (wr_lay)     layout_o <= layout_e'(wr_data_i[0]);
      end
   end

   AST_LAYOUT_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_mode_i |=> $stable(layout_o)); // R7

endmodule

// File: rtl/slot_irq_prio_rank.sv
module slot_irq_prio_rank
   import slot_irq_prio_pkg::*;
#(
   parameter int N_Y    = 4,
   parameter int N_X    = 5,
   parameter int N_Z    = 7,
   parameter int SLOTS  = 8,
   parameter int SLOT_W = 3,
   parameter int NSRC   = 23,
   parameter int POS_W  = 5
) (
   input  logic [N_Y-1:0][SLOT_W-1:0] y_map_i,
   input  logic [N_X-1:0][SLOT_W-1:0] x_map_i,
   input  logic [N_Z-1:0][SLOT_W-1:0] z_map_i,
   input  layout_e                    layout_i,
   output logic [NSRC-1:0][POS_W-1:0] pos_o,
   output logic [NSRC-1:0]            shadow_o,
   output logic                       collide_o
);

   localparam int Y_ID = 1;
   localparam int X_ID = Y_ID + N_Y;
   localparam int Z_ID = X_ID + N_X;
   localparam int F_ID = Z_ID + N_Z;

   assign pos_o[0]    = '0;
   assign shadow_o[0] = 1'b0;

   for (genvar k = 0; k < N_Y; k++) begin : g_y
      assign pos_o[Y_ID+k] = POS_W'(y_pos(int'(y_map_i[k]), SLOTS, layout_i));
      always_comb begin
         shadow_o[Y_ID+k] = 1'b0;
         for (int j = 0; j < k; j++)
            if (y_map_i[j] == y_map_i[k]) shadow_o[Y_ID+k] = 1'b1;
      end
   end

   for (genvar k = 0; k < N_X; k++) begin : g_x
      assign pos_o[X_ID+k] = POS_W'(x_pos(int'(x_map_i[k]), SLOTS, layout_i));
      always_comb begin
         shadow_o[X_ID+k] = 1'b0;
         for (int j = 0; j < k; j++)
            if (x_map_i[j] == x_map_i[k]) shadow_o[X_ID+k] = 1'b1;
      end
   end

   for (genvar k = 0; k < N_Z; k++) begin : g_z
      assign pos_o[Z_ID+k] = POS_W'(z_pos(int'(z_map_i[k]), SLOTS, layout_i));
      always_comb begin
         shadow_o[Z_ID+k] = 1'b0;
         for (int j = 0; j < k; j++)
            if (z_map_i[j] == z_map_i[k]) shadow_o[Z_ID+k] = 1'b1;
      end
   end

   for (genvar f = 0; f < FIXED_SRCS; f++) begin : g_f
      assign pos_o[F_ID+f]    = POS_W'(f_pos(f, SLOTS, layout_i));
      assign shadow_o[F_ID+f] = 1'b0;
   end

   assign collide_o = |shadow_o;

endmodule

// File: rtl/slot_irq_prio_pick.sv
module slot_irq_prio_pick #(
   parameter int NSRC  = 23,
   parameter int POS_W = 5,
   parameter int ID_W  = 5
) (
   input  logic [NSRC-1:0]            elig_i,
   input  logic [NSRC-1:0][POS_W-1:0] pos_i,
   output logic                       any_o,
   output logic [ID_W-1:0]            win_o
);

   logic [POS_W-1:0] best;

   // strict compare in ID order: equal positions resolve to the lower ID
   always_comb begin
      any_o = 1'b0;
      best  = '1;
      win_o = '1;
      for (int i = 0; i < NSRC; i++) begin
         if (elig_i[i] && (!any_o || pos_i[i] < best)) begin
            any_o = 1'b1;
            best  = pos_i[i];
            win_o = ID_W'(i);
         end
      end
   end

endmodule

// File: rtl/slot_irq_prio.sv
module slot_irq_prio
   import slot_irq_prio_pkg::*;
#(
   parameter int N_SER   = 4,
   parameter int N_FAST  = 3,
   parameter int N_MULTI = 2,
   parameter int N_GPIN  = 5,
   parameter int SLOTS   = 8,
   parameter int DATA_W  = 32,
   localparam int N_Y    = N_SER,
   localparam int N_X    = N_FAST + N_MULTI,
   localparam int N_Z    = N_GPIN + 2,
   localparam int NSRC   = 1 + N_Y + N_X + N_Z + FIXED_SRCS,
   localparam int ID_W   = $clog2(NSRC + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NSRC-1:0]   req_i,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              cfg_mode_i,
   input  logic              ack_i,
   output logic              irq_o,
   output logic [ID_W-1:0]   vec_o,
   output logic              cfg_err_o
);

   localparam int SLOT_W = $clog2(SLOTS);
   localparam int N_POS  = 3 * SLOTS + 1 + FIXED_SRCS;
   localparam int POS_W  = $clog2(N_POS);
   localparam logic [ID_W-1:0] NO_SRC = '1;

   initial begin
      assert (SLOTS >= 3 && (1 << SLOT_W) == SLOTS)
         else $error("SLOTS must be a power of two of at least 4");
      assert (N_Y <= SLOTS && N_X <= SLOTS && N_Z <= SLOTS)
         else $error("a class has more sources than slots");
      assert (N_Z * SLOT_W <= DATA_W && NSRC <= DATA_W && N_X * SLOT_W <= DATA_W)
         else $error("register fields exceed DATA_W");
   end

   logic [N_Y-1:0][SLOT_W-1:0] y_map;
   logic [N_X-1:0][SLOT_W-1:0] x_map;
   logic [N_Z-1:0][SLOT_W-1:0] z_map;
   logic [NSRC-1:0]            en;
   layout_e                    layout;
   logic [NSRC-1:0][POS_W-1:0] pos;
   logic [NSRC-1:0]            shadow;
   logic                       collide;
   logic [NSRC-1:0]            elig;
   logic                       any_elig;
   logic [ID_W-1:0]            win;

   slot_irq_prio_regs #(
      .N_Y(N_Y), .N_X(N_X), .N_Z(N_Z), .SLOT_W(SLOT_W),
      .NSRC(NSRC), .DATA_W(DATA_W)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .cfg_mode_i (cfg_mode_i),
      .y_map_o    (y_map),
      .x_map_o    (x_map),
      .z_map_o    (z_map),
      .en_o       (en),
      .layout_o   (layout)
   );

   slot_irq_prio_rank #(
      .N_Y(N_Y), .N_X(N_X), .N_Z(N_Z), .SLOTS(SLOTS),
      .SLOT_W(SLOT_W), .NSRC(NSRC), .POS_W(POS_W)
   ) u_rank (
      .y_map_i   (y_map),
      .x_map_i   (x_map),
      .z_map_i   (z_map),
      .layout_i  (layout),
      .pos_o     (pos),
      .shadow_o  (shadow),
      .collide_o (collide)
   );

   assign elig = req_i & en & ~shadow;

   slot_irq_prio_pick #(
      .NSRC(NSRC), .POS_W(POS_W), .ID_W(ID_W)
   ) u_pick (
      .elig_i (elig),
      .pos_i  (pos),
      .any_o  (any_elig),
      .win_o  (win)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_o     <= 1'b0;
         vec_o     <= NO_SRC;
         cfg_err_o <= 1'b0;
      end else begin
         irq_o     <= any_elig;
         cfg_err_o <= cfg_err_o | collide;
         if (ack_i) vec_o <= any_elig ? win : NO_SRC;
      end
   end

   AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ack_i |=> $stable(vec_o)); // R10

   AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_err_o |=> cfg_err_o); // R8

   AST_COLLIDE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      collide |=> cfg_err_o); // R8

   AST_BUS_ERR_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && req_i[0] && en[0]) |=> (vec_o == '0)); // R3

   AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && any_elig) |=> (irq_o && vec_o != NO_SRC)); // R9

endmodule

// File: tb/slot_irq_prio_bench.sv
`timescale 1ns/1ps
module slot_irq_prio_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [22:0] req = '0;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        cfg = 1'b0;
   logic        ack = 1'b0;
   logic        irq;
   logic [4:0]  vec;
   logic        err;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model state
   int m_y[4];
   int m_x[5];
   int m_z[7];
   logic [22:0] m_en;
   logic m_lay;
   logic m_err;
   logic exp_irq, exp_err;
   int exp_vec;

   always #2 clk = ~clk;

   slot_irq_prio u_slot_irq_prio (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(we),
      .wr_addr_i(addr), .wr_data_i(wdata), .cfg_mode_i(cfg), .ack_i(ack),
      .irq_o(irq), .vec_o(vec), .cfg_err_o(err)
   );

   task automatic chk(input string tag, input int act, input int expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   // table position of a source from the R4 / R5 orderings
   function automatic int pos_of(input int id);
      int s;
      if (id == 0) return 0;
      if (!m_lay) begin
         if (id <= 4)  return 1 + m_y[id-1];
         if (id <= 9)  return 9 + m_x[id-5];
         if (id <= 16) return 17 + m_z[id-10];
         return 25 + (id - 17);
      end
      if (id <= 4) begin
         s = m_y[id-1];
         return (s < 6) ? 2 + 2*s : ((s == 6) ? 26 : 30);
      end
      if (id <= 9) begin
         s = m_x[id-5];
         return (s < 6) ? 1 + 2*s : ((s == 6) ? 13 : 14);
      end
      if (id <= 16) return 15 + m_z[id-10];
      case (id)
         17: return 23;
         18: return 24;
         19: return 25;
         20: return 27;
         21: return 28;
         default: return 29;
      endcase
   endfunction

   // R8: displaced when a lower ID of the same class holds the same slot
   function automatic bit displaced(input int id);
      if (id >= 1 && id <= 4) begin
         for (int j = 1; j < id; j++) if (m_y[j-1] == m_y[id-1]) return 1'b1;
      end else if (id >= 5 && id <= 9) begin
         for (int j = 5; j < id; j++) if (m_x[j-5] == m_x[id-5]) return 1'b1;
      end else if (id >= 10 && id <= 16) begin
         for (int j = 10; j < id; j++) if (m_z[j-10] == m_z[id-10]) return 1'b1;
      end
      return 1'b0;
   endfunction

   function automatic bit any_clash();
      for (int i = 0; i < 23; i++) if (displaced(i)) return 1'b1;
      return 1'b0;
   endfunction

   function automatic int winner(input logic [22:0] r);
      int best = 99;
      int w = 31;
      for (int i = 0; i < 23; i++)
         if (r[i] && m_en[i] && !displaced(i) && pos_of(i) < best) begin
            best = pos_of(i);
            w = i;
         end
      return w;
   endfunction

   task automatic cycle(input logic [22:0] r, input logic a, input logic w,
                        input logic [2:0] ad, input logic [31:0] d,
                        input logic c, input string tag);
      int wv;
      req = r; ack = a; we = w; addr = ad; wdata = d; cfg = c;
      wv = winner(r);
      exp_irq = (wv != 31);
      if (a) exp_vec = wv;
      exp_err = m_err | any_clash();
      m_err = exp_err;
      if (w) begin
         case (ad)
            3'd0: for (int k = 0; k < 4; k++) m_y[k] = int'(d[3*k +: 3]);
            3'd1: for (int k = 0; k < 5; k++) m_x[k] = int'(d[3*k +: 3]);
            3'd2: for (int k = 0; k < 7; k++) m_z[k] = int'(d[3*k +: 3]);
            3'd3: m_en = d[22:0];
            3'd4: if (c) m_lay = d[0];
            default: ;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      chk({tag, " irq (R9)"}, int'(irq), int'(exp_irq));
      chk({tag, " vec (R10)"}, int'(vec), exp_vec);
      chk({tag, " err (R8)"}, int'(err), int'(exp_err));
      we = 1'b0; ack = 1'b0; cfg = 1'b0;
   endtask

   function automatic logic [22:0] bit_of(input int id);
      return 23'(1) << id;
   endfunction

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual hang expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int k = 0; k < 4; k++) m_y[k] = k;
      for (int k = 0; k < 5; k++) m_x[k] = k;
      for (int k = 0; k < 7; k++) m_z[k] = k;
      m_en = '0; m_lay = 1'b0; m_err = 1'b0; exp_vec = 31;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq", int'(irq), 0);
      chk("R1 vec", int'(vec), 31);
      chk("R1 err", int'(err), 0);
      // R1: enables start at zero, so a request gives nothing
      cycle(bit_of(0) | bit_of(4), 1, 0, 0, 0, 0, "R1 disabled");
      chk("R1 disabled vec", int'(vec), 31);

      // R2: enable everything via address 3
      cycle('0, 0, 1, 3'd3, 32'h007F_FFFF, 0, "R2 enable");
      // R4: grouped: Y4 (ID4, pos 4) beats X1 (ID5, pos 9)
      cycle(bit_of(4) | bit_of(5), 1, 0, 0, 0, 0, "R4");
      chk("R4 Y before X", int'(vec), 4);
      // R7: spread under configuration
      cycle('0, 0, 1, 3'd4, 32'd1, 1, "R7 set spread");
      cycle(bit_of(4) | bit_of(5), 1, 0, 0, 0, 0, "R5");
      chk("R5 X1 leads", int'(vec), 5);
      // R6: move ID4 to Y7
      cycle('0, 0, 1, 3'd0, {20'd0, 3'd6, 3'd2, 3'd1, 3'd0}, 0, "R6 remap");
      cycle(bit_of(4) | bit_of(19), 1, 0, 0, 0, 0, "R5 low");
      chk("R5 Y7 below ID19", int'(vec), 19);
      cycle(bit_of(4) | bit_of(20), 1, 0, 0, 0, 0, "R5 low2");
      chk("R5 Y7 above ID20", int'(vec), 4);
      // R7: layout write outside configuration is ignored
      cycle('0, 0, 1, 3'd4, 32'd0, 0, "R7 locked");
      cycle(bit_of(4) | bit_of(19), 1, 0, 0, 0, 0, "R7");
      chk("R7 layout kept", int'(vec), 19);
      cycle('0, 0, 1, 3'd4, 32'd0, 1, "R7 unlock");
      cycle(bit_of(4) | bit_of(19), 1, 0, 0, 0, 0, "R4 back");
      chk("R4 grouped Y7", int'(vec), 4);
      // R2: unused address ignored
      cycle('0, 0, 1, 3'd6, 32'hFFFF_FFFF, 1, "R2 unused");
      cycle(bit_of(4) | bit_of(19), 1, 0, 0, 0, 0, "R2 unused chk");
      chk("R2 unused addr", int'(vec), 4);
      // R3: bus error and fixed order
      cycle('1, 1, 0, 0, 0, 0, "R3 all");
      chk("R3 bus error", int'(vec), 0);
      cycle(bit_of(17) | bit_of(18) | bit_of(22), 1, 0, 0, 0, 0, "R3 fixed");
      chk("R3 fixed order", int'(vec), 17);
      // R10: hold without ack
      cycle(bit_of(20), 1, 0, 0, 0, 0, "R10 load");
      cycle(bit_of(0) | bit_of(20), 0, 0, 0, 0, 0, "R10 hold");
      chk("R10 held", int'(vec), 20);
      chk("R9 pending", int'(irq), 1);
      cycle('0, 1, 0, 0, 0, 0, "R10 empty");
      chk("R10 none", int'(vec), 31);
      // R9: a disabled source raises nothing
      cycle('0, 0, 1, 3'd3, ~(32'd1 << 21), 0, "R9 mask");
      cycle(bit_of(21), 1, 0, 0, 0, 0, "R9");
      chk("R9 masked", int'(irq), 0);
      // R6: rotation between ID1 and ID2
      cycle('0, 0, 1, 3'd0, {20'd0, 3'd3, 3'd2, 3'd0, 3'd1}, 0, "R6 rot");
      cycle(bit_of(1) | bit_of(2), 1, 0, 0, 0, 0, "R6");
      chk("R6 rotated", int'(vec), 2);
      // R8: all serial sources in slot 2
      cycle('0, 0, 1, 3'd0, {20'd0, 3'd2, 3'd2, 3'd2, 3'd2}, 0, "R8 clash");
      cycle(bit_of(2), 1, 0, 0, 0, 0, "R8 loser");
      chk("R8 loser silent", int'(vec), 31);
      chk("R8 flag", int'(err), 1);
      cycle(bit_of(1) | bit_of(2), 1, 0, 0, 0, 0, "R8 keeper");
      chk("R8 keeper", int'(vec), 1);

      for (int n = 0; n < 3000; n++) begin
         logic [22:0] r;
         logic [2:0] ra;
         r = 23'($urandom & $urandom & $urandom);
         ra = 3'($urandom % 8);
         cycle(r, 1'($urandom), ($urandom % 5) == 0, ra, $urandom,
               ($urandom % 4) == 0, "R6 random");
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule